// File: doc/BRIEF.md
# VLIW Issue-Slot Assigner

This block places the entries of one decoded instruction packet onto a four-wide issue stage. Each entry carries a four-bit mask of the slots it may legally use, plus three flags: memory-like, duplex sub-instruction and loop end. A pulse on `start_i` captures the packet. The block walks the entries one per clock and gives each one the highest legal slot that is still free. It then runs three fix-up passes over the result and checks that no slot is used twice. At the end it pulses `done_o` and presents a two-bit slot per entry together with a legality flag.

The slot vector and the legality flag change only in the cycle in which `done_o` is high. They keep their values until the next packet completes, so the consumer can sample them at any time after the pulse. The legal-slot masks come from an earlier decode stage and are not derived here.

Top module: `slot_assigner`

## Requirements
- R1: After reset, `done_o` and `valid_o` are 0 and every field of `slots_o` is 0.
- R2: Entries are visited in index order, starting with a free-slot limit of 3. A non-loop-end entry takes the highest slot at or below the limit whose bit is set in its mask (mask bit k means slot k). The limit then becomes one below the slot taken.
- R3: If a non-loop-end entry has no legal slot at or below the limit, the packet is reported with `valid_o` = 0.
- R4: Memory fix-up. Scanning from the highest entry index down, the first memory-flagged entry is moved to slot 0 and every later one is moved to slot 1.
- R5: Sub-instruction fix-up. This pass runs after R4 and uses the same backward rule on sub-instruction-flagged entries: the first is moved to slot 0, the rest to slot 1.
- R6: Backfill. If some entry holds slot 1 and no non-loop-end entry holds slot 0, the lowest-index entry holding slot 1 is moved to slot 0.
- R7: A loop-end entry always reports slot 0. It uses no countdown slot and is ignored by the fix-ups, the backfill and the conflict check. Loop end takes precedence over the other flags.
- R8: `valid_o` is 1 only when no two non-loop-end entries below `count_i` report the same slot.
- R9: Entries at index `count_i` or above report slot 0. Entry i occupies `slots_o[2i+1:2i]`.
- R10: `done_o` is high for exactly one cycle per packet. `valid_o` and `slots_o` change only in that cycle. A `start_i` that arrives while a packet is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Capture the packet and begin assignment (accepted only when idle) |
| count_i | input | CW ($clog2(NUM_ENTRIES+1)) | Number of entries in the packet |
| legal_i | input | NUM_ENTRIES*4 | Legal-slot mask per entry; entry i at bits [4i+3:4i] |
| mem_i | input | NUM_ENTRIES | Memory-like flag per entry |
| sub_i | input | NUM_ENTRIES | Duplex sub-instruction flag per entry |
| lend_i | input | NUM_ENTRIES | Loop-end flag per entry |
| done_o | output | 1 | One-cycle completion pulse |
| valid_o | output | 1 | Assignment is legal |
| slots_o | output | NUM_ENTRIES*2 | Assigned slot per entry; entry i at bits [2i+1:2i] |

## Verification
The hardest situations to reach are the ones where the passes interact. One is a loop end that sits in slot 0 while a real entry occupies slot 1, so the backfill must not treat the loop end as occupying slot 0. Another is a packet in which memory and sub-instruction fix-ups pile entries onto slots 0 and 1 until they collide. Directed packets build each of these cases with narrow masks that steer the countdown onto slot 1, and with mixed flags. Weighted random packets, biased toward all-ones masks so that many of them stay legal, then cover the remaining mixes. A second start pulse sent during a run checks that the packet in progress is not disturbed.

// File: rtl/slot_assign_pkg.sv
package slot_assign_pkg;

    localparam int SLOTS = 4;
    localparam int SW    = $clog2(SLOTS);

    typedef logic [SW-1:0]    slot_t;
    typedef logic [SLOTS-1:0] smask_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COUNT,
        ST_FINISH
    } state_e;

    typedef struct packed {
        logic   mem;
        logic   sub;
        logic   lend;
        smask_t legal;
    } entry_t;

    localparam slot_t SLOT_ZERO = slot_t'(0);
    localparam slot_t SLOT_ONE  = slot_t'(1);

    // mask of all slots strictly below s
    function automatic smask_t below_mask(slot_t s);
        smask_t m;
        m = '0;
        for (int k = 0; k < SLOTS; k++) begin
            if (slot_t'(k) < s) m[k] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/slot_fixup.sv
module slot_fixup
    import slot_assign_pkg::*;
#(
    parameter  int NUM_ENTRIES = 6,
    localparam int CW          = $clog2(NUM_ENTRIES + 1)
) (
    input  logic [CW-1:0] count_i,
    input  entry_t        ent_i  [NUM_ENTRIES],
    input  slot_t         slot_i [NUM_ENTRIES],
    output slot_t         slot_o [NUM_ENTRIES]
);

    always_comb begin
        logic hit_mem;
        logic hit_sub;
        logic seen0;
        logic seen1;
        int   idx1;
        hit_mem = 1'b0;
        hit_sub = 1'b0;
        seen0   = 1'b0;
        seen1   = 1'b0;
        idx1    = 0;
        for (int i = 0; i < NUM_ENTRIES; i++) slot_o[i] = slot_i[i];

        // memory-like entries, backward scan
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (CW'(i) < count_i && ent_i[i].mem && !ent_i[i].lend) begin
                slot_o[i] = hit_mem ? SLOT_ONE : SLOT_ZERO;
                hit_mem   = 1'b1;
            end
        end

        // duplex sub-instructions, backward scan
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (CW'(i) < count_i && ent_i[i].sub && !ent_i[i].lend) begin
                slot_o[i] = hit_sub ? SLOT_ONE : SLOT_ZERO;
                hit_sub   = 1'b1;
            end
        end

        // backfill slot 0 from slot 1
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (CW'(i) < count_i && !ent_i[i].lend) begin
                if (slot_o[i] == SLOT_ZERO) seen0 = 1'b1;
                if (slot_o[i] == SLOT_ONE) begin
                    seen1 = 1'b1;
                    idx1  = i;
                end
            end
        end
        if (!seen0 && seen1) begin
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                if (i == idx1) slot_o[i] = SLOT_ZERO;
            end
        end
    end

endmodule

// File: rtl/slot_conflict.sv
module slot_conflict
    import slot_assign_pkg::*;
#(
    parameter  int NUM_ENTRIES = 6,
    localparam int CW          = $clog2(NUM_ENTRIES + 1)
) (
    input  logic [CW-1:0] count_i,
    input  entry_t        ent_i  [NUM_ENTRIES],
    input  slot_t         slot_i [NUM_ENTRIES],
    output logic          clash_o
);

    always_comb begin
        clash_o = 1'b0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            for (int j = i + 1; j < NUM_ENTRIES; j++) begin
                if (CW'(j) < count_i && !ent_i[i].lend && !ent_i[j].lend &&
                    slot_i[i] == slot_i[j]) begin
                    clash_o = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/slot_assigner.sv
module slot_assigner
    import slot_assign_pkg::*;
#(
    parameter  int NUM_ENTRIES = 6,
    localparam int CW          = $clog2(NUM_ENTRIES + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start_i,
    input  logic [CW-1:0]              count_i,
    input  logic [NUM_ENTRIES*SLOTS-1:0] legal_i,
    input  logic [NUM_ENTRIES-1:0]     mem_i,
    input  logic [NUM_ENTRIES-1:0]     sub_i,
    input  logic [NUM_ENTRIES-1:0]     lend_i,
    output logic                       done_o,
    output logic                       valid_o,
    output logic [NUM_ENTRIES*SW-1:0]  slots_o
);

    state_e        st_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] idx_q;
    smask_t        avail_q;
    logic          bad_q;
    entry_t        ent_q  [NUM_ENTRIES];
    slot_t         slot_q [NUM_ENTRIES];
    slot_t         fix_slot [NUM_ENTRIES];
    logic          clash;

    entry_t        cur;
    smask_t        cand;
    slot_t         pick;
    logic          found;
    logic [CW-1:0] cnt_d;

    assign cnt_d = (count_i > CW'(NUM_ENTRIES)) ? CW'(NUM_ENTRIES) : count_i;

    always_comb begin
        cur = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (CW'(i) == idx_q) cur = ent_q[i];
        end
        cand  = cur.legal & avail_q;
        pick  = SLOT_ZERO;
        found = 1'b0;
        for (int k = 0; k < SLOTS; k++) begin
            if (cand[k]) begin
                pick  = slot_t'(k);
                found = 1'b1;
            end
        end
    end

    slot_fixup #(.NUM_ENTRIES(NUM_ENTRIES)) u_fixup (
        .count_i (cnt_q),
        .ent_i   (ent_q),
        .slot_i  (slot_q),
        .slot_o  (fix_slot)
    );

    slot_conflict #(.NUM_ENTRIES(NUM_ENTRIES)) u_conflict (
        .count_i (cnt_q),
        .ent_i   (ent_q),
        .slot_i  (fix_slot),
        .clash_o (clash)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            avail_q <= '1;
            bad_q   <= 1'b0;
            done_o  <= 1'b0;
            valid_o <= 1'b0;
            slots_o <= '0;
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                ent_q[i]  <= '0;
                slot_q[i] <= SLOT_ZERO;
            end
        end else begin
            done_o <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        cnt_q   <= cnt_d;
                        idx_q   <= '0;
                        avail_q <= '1;
                        bad_q   <= 1'b0;
                        for (int i = 0; i < NUM_ENTRIES; i++) begin
                            ent_q[i].legal <= legal_i[i*SLOTS +: SLOTS];
                            ent_q[i].mem   <= mem_i[i];
                            ent_q[i].sub   <= sub_i[i];
                            ent_q[i].lend  <= lend_i[i];
                            slot_q[i]      <= SLOT_ZERO;
                        end
                        st_q <= ST_COUNT;
                    end
                end
                ST_COUNT: begin
                    if (idx_q >= cnt_q) begin
                        st_q <= ST_FINISH;
                    end else if (cur.lend) begin
                        idx_q <= idx_q + 1'b1;
                    end else if (!found) begin
                        bad_q <= 1'b1;
                        st_q  <= ST_FINISH;
                    end else begin
                        for (int i = 0; i < NUM_ENTRIES; i++) begin
                            if (CW'(i) == idx_q) slot_q[i] <= pick;
                        end
                        avail_q <= below_mask(pick);
                        idx_q   <= idx_q + 1'b1;
                    end
                end
                ST_FINISH: begin
                    for (int i = 0; i < NUM_ENTRIES; i++) begin
                        slots_o[i*SW +: SW] <= fix_slot[i];
                    end
                    valid_o <= !bad_q && !clash;
                    done_o  <= 1'b1;
                    st_q    <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/slot_assign_chk.sv
module slot_assign_chk
    import slot_assign_pkg::*;
#(
    parameter  int NUM_ENTRIES = 6,
    localparam int CW          = $clog2(NUM_ENTRIES + 1)
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      start_i,
    input logic [CW-1:0]             count_i,
    input logic [NUM_ENTRIES-1:0]    lend_i,
    input logic                      done_o,
    input logic                      valid_o,
    input logic [NUM_ENTRIES*SW-1:0] slots_o
);

    logic                   busy_q;
    logic [CW-1:0]          cnt_l;
    logic [NUM_ENTRIES-1:0] lend_l;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_l  <= '0;
            lend_l <= '0;
        end else if (!busy_q && start_i) begin
            busy_q <= 1'b1;
            cnt_l  <= count_i;
            lend_l <= lend_i;
        end else if (done_o) begin
            busy_q <= 1'b0;
        end
    end

    logic unused_zero, lend_zero, distinct;
    always_comb begin
        unused_zero = 1'b1;
        lend_zero   = 1'b1;
        distinct    = 1'b1;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (CW'(i) >= cnt_l && slots_o[i*SW +: SW] != SLOT_ZERO) unused_zero = 1'b0;
            if (CW'(i) < cnt_l && lend_l[i] && slots_o[i*SW +: SW] != SLOT_ZERO) lend_zero = 1'b0;
            for (int j = i + 1; j < NUM_ENTRIES; j++) begin
                if (CW'(j) < cnt_l && !lend_l[i] && !lend_l[j] &&
                    slots_o[i*SW +: SW] == slots_o[j*SW +: SW]) distinct = 1'b0;
            end
        end
    end

    p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_done_after_start_r10: assert property (@(posedge clk) disable iff (rst)
        done_o |-> busy_q);

    p_hold_outputs_r10: assert property (@(posedge clk) disable iff (rst)
        !$stable({valid_o, slots_o}) |-> done_o);

    p_unused_zero_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> unused_zero);

    p_lend_slot0_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |-> lend_zero);

    p_valid_distinct_r8: assert property (@(posedge clk) disable iff (rst)
        (done_o && valid_o) |-> distinct);

endmodule

bind slot_assigner slot_assign_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .count_i (count_i),
    .lend_i  (lend_i),
    .done_o  (done_o),
    .valid_o (valid_o),
    .slots_o (slots_o)
);

// File: tb/tb_slot_assigner.sv
module tb_slot_assigner;
    localparam int N  = 6;
    localparam int CW = $clog2(N + 1);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start_i = 1'b0;
    logic [CW-1:0]   count_i = '0;
    logic [N*4-1:0]  legal_i = '0;
    logic [N-1:0]    mem_i = '0, sub_i = '0, lend_i = '0;
    logic            done_o, valid_o;
    logic [N*2-1:0]  slots_o;

    always #4 clk = ~clk;

    slot_assigner #(.NUM_ENTRIES(N)) dut (
        .clk(clk), .rst(rst), .start_i(start_i), .count_i(count_i),
        .legal_i(legal_i), .mem_i(mem_i), .sub_i(sub_i), .lend_i(lend_i),
        .done_o(done_o), .valid_o(valid_o), .slots_o(slots_o)
    );

    int checks = 0;
    int fails  = 0;
    logic [N*2:0] exp_q[$];
    string        tag_q[$];
    int           cnt_q[$];
    logic [N*2:0] last_exp;

    // expected result {valid, slots}, built from the requirements
    function automatic logic [N*2:0] model(int n, logic [N*4-1:0] lg,
                                          logic [N-1:0] mm, logic [N-1:0] sb,
                                          logic [N-1:0] le);
        int s[N];
        bit ok = 1;
        bit clash = 0;
        int lim = 3;
        bit h;
        bit f0;
        int f1;
        logic [N*2-1:0] v;
        for (int i = 0; i < N; i++) s[i] = 0;
        for (int i = 0; i < n; i++) begin
            if (!le[i]) begin
                while (lim >= 0 && !lg[i*4 + lim]) lim--;
                if (lim < 0) begin ok = 0; break; end
                s[i] = lim;
                lim--;
            end
        end
        h = 0;
        for (int i = n - 1; i >= 0; i--)
            if (mm[i] && !le[i]) begin s[i] = h ? 1 : 0; h = 1; end
        h = 0;
        for (int i = n - 1; i >= 0; i--)
            if (sb[i] && !le[i]) begin s[i] = h ? 1 : 0; h = 1; end
        f0 = 0; f1 = -1;
        for (int i = n - 1; i >= 0; i--)
            if (!le[i]) begin
                if (s[i] == 0) f0 = 1;
                if (s[i] == 1) f1 = i;
            end
        if (!f0 && f1 >= 0) s[f1] = 0;
        for (int i = 0; i < n; i++)
            for (int j = i + 1; j < n; j++)
                if (!le[i] && !le[j] && s[i] == s[j]) clash = 1;
        for (int i = 0; i < N; i++) v[i*2 +: 2] = 2'(s[i]);
        return {ok && !clash, v};
    endfunction

    task automatic check(string tag, logic [N*2:0] act, logic [N*2:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected item on each done pulse
    logic prev_done = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (done_o && prev_done) check("R10 done width", 1, 0);
            if (done_o) begin
                if (exp_q.size() == 0) check("R10 unexpected done", 1, 0);
                else begin
                    logic [N*2:0] e;
                    string t;
                    int c;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    c = cnt_q.pop_front();
                    last_exp = e;
                    check(t, {valid_o, slots_o}, e);
                    for (int i = c; i < N; i++)
                        check("R9 unused field", {11'd0, slots_o[i*2 +: 2]}, '0);
                end
            end
            prev_done <= done_o;
        end
    end

    task automatic run(string tag, int n, logic [N*4-1:0] lg, logic [N-1:0] mm,
                       logic [N-1:0] sb, logic [N-1:0] le, bit poke);
        exp_q.push_back(model(n, lg, mm, sb, le));
        tag_q.push_back(tag);
        cnt_q.push_back(n);
        @(negedge clk);
        count_i = CW'(n); legal_i = lg; mem_i = mm; sub_i = sb; lend_i = le;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            @(negedge clk);
            count_i = CW'(1); legal_i = '0; mem_i = '1; sub_i = '1; lend_i = '0;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (!done_o) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset", {done_o, valid_o, slots_o}, '0);

        // R2: all-legal countdown gives 3,2,1,0
        run("R2 countdown", 4, {4'hF, 4'hF, 4'hF, 4'hF}, '0, '0, '0, 0);
        // R3: slot 2 then slot 3 only -> exhausted
        run("R3 exhausted", 2, {4'h8, 4'h4}, '0, '0, '0, 0);
        // R4: two memory entries -> e1 slot0, e0 slot1
        run("R4 mem fixup", 2, {4'hF, 4'hF}, 6'b000011, '0, '0, 0);
        // R5: duplex pair on e1,e2 -> e2 slot0, e1 slot1, e0 slot3
        run("R5 sub fixup", 3, {4'hF, 4'hF, 4'hF}, '0, 6'b000110, '0, 0);
        // R6: only slot 1 legal -> backfilled to slot 0
        run("R6 backfill", 1, {4'h2}, '0, '0, '0, 0);
        // R7: loop end does not occupy slot 0; e2 backfilled to 0
        run("R7 loop end", 3, {4'h2, 4'hF, 4'hF}, '0, '0, 6'b000010, 0);
        // R8: memory pair plus third entry collides on slot 1
        run("R8 conflict", 3, {4'hF, 4'hF, 4'hF}, 6'b000011, '0, '0, 0);
        // R8: memory and duplex pairs collide
        run("R8 mem+sub clash", 4, {4'hF, 4'hF, 4'hF, 4'hF}, 6'b000011, 6'b001100, '0, 0);
        // R10: start while busy is ignored
        run("R10 busy start", 4, {4'hF, 4'hF, 4'hF, 4'hF}, 6'b000001, '0, '0, 1);
        // R10: outputs hold after done
        repeat (5) @(negedge clk);
        check("R10 hold", {valid_o, slots_o}, last_exp);

        for (int v = 0; v < 60; v++) begin
            logic [N*4-1:0] lg;
            logic [N-1:0] mm, sb, le;
            int n;
            n = 1 + int'($urandom_range(0, N - 1));
            for (int i = 0; i < N; i++) begin
                lg[i*4 +: 4] = ($urandom_range(0, 1) == 0) ? 4'hF : 4'($urandom_range(1, 15));
                mm[i] = ($urandom_range(0, 3) == 0);
                sb[i] = ($urandom_range(0, 3) == 0);
                le[i] = ($urandom_range(0, 6) == 0);
            end
            run("R2 random", n, lg, mm, sb, le, 0);
        end

        @(negedge clk);
        if (exp_q.size() != 0) check("R10 missing done", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule